// File: doc/BRIEF.md
# Integer Add and Logic Unit

This is a purely combinational execute slice for a 64-bit register machine. It adds two register operands, or a register and a 16-bit immediate, either as 32-bit words or as 64-bit doublewords. It also computes a bitwise AND of a register with another register or with an immediate. A single 64-bit adder serves both add widths. Word results are taken from the low half of the adder output.

Each add width comes in two variants: a trapping add that flags signed overflow, and a wrapping add that never flags. When the trap flag is raised, the unit also drops its write enable so that the destination register is left untouched. Decode, register file access and the handling of the trap are done by surrounding logic.

Operation codes on `op_sel` are as follows:

- 0: trapping word add
- 1: wrapping word add
- 2: trapping doubleword add
- 3: wrapping doubleword add
- 4: AND
- 5 to 7: reserved

Top module: `int_add_logic_unit`

## Requirements
- R1: With `op_sel`=0, the unit adds the low 32 bits of the two operands and raises `ovf_trap` exactly when the sum overflows as a signed 32-bit value. The second operand is either register B or the immediate.
- R2: With `op_sel`=1, the unit returns the wrapped 32-bit sum and never raises `ovf_trap`, whatever the operands.
- R3: With `op_sel`=2, the unit adds the full 64-bit operands and raises `ovf_trap` exactly when the sum overflows as a signed 64-bit value.
- R4: With `op_sel`=3, the unit returns the wrapped 64-bit sum and never raises `ovf_trap`.
- R5: For the add codes (0 to 3) with `use_imm`=1, the 16-bit immediate is sign-extended from its bit 15 before it is added.
- R6: Word adds (codes 0 and 1) ignore operand bits 63:32. Their result is the 32-bit sum sign-extended from bit 31 to 64 bits.
- R7: With `op_sel`=4, the result is A AND B when `use_imm`=0. When `use_imm`=1, it is A AND the immediate zero-extended to 64 bits.
- R8: For every valid code (0 to 4), `wr_en` is the inverse of `ovf_trap`.
- R9: Reserved codes (5 to 7) give a zero result, `ovf_trap`=0 and `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| imm | input | 16 | Immediate field |
| op_sel | input | 3 | Operation code |
| use_imm | input | 1 | Use the immediate in place of opnd_b |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Signed overflow trap request |
| wr_en | output | 1 | Destination write enable |

## Verification
The unit holds no state, so a wrong internal value shows at the ports in the same evaluation as the inputs that exposed it. The likely faults are a wrong extension of the immediate, overflow sensed on the wrong bit, or a trap leaking into a wrapping variant. Each of these shows as a wrong result word or a wrong trap/write pair on the very vector that exercises it. The stimulus therefore targets the sign boundaries at bits 15, 31 and 63, and it places junk in the upper operand halves for word adds.

// File: rtl/int_add_logic_unit.sv
module int_add_logic_unit #(
  parameter int DW  = 64,
  parameter int WW  = 32,
  parameter int IW  = 16,
  parameter int OPW = 3
) (
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic [IW-1:0]  imm,
  input  logic [OPW-1:0] op_sel,
  input  logic           use_imm,
  output logic [DW-1:0]  result,
  output logic           ovf_trap,
  output logic           wr_en
);

  localparam int XW = DW - IW;
  localparam int HW = DW - WW;
  localparam logic [OPW-1:0] OP_ADDW_T = OPW'(0);
  localparam logic [OPW-1:0] OP_ADDW_U = OPW'(1);
  localparam logic [OPW-1:0] OP_ADDD_T = OPW'(2);
  localparam logic [OPW-1:0] OP_ADDD_U = OPW'(3);
  localparam logic [OPW-1:0] OP_AND    = OPW'(4);

  logic [DW-1:0] imm_ext, rhs, sum, word_res;
  logic          is_word, is_dword, is_and, ovf_w, ovf_d;

  assign is_word  = (op_sel == OP_ADDW_T) || (op_sel == OP_ADDW_U);
  assign is_dword = (op_sel == OP_ADDD_T) || (op_sel == OP_ADDD_U);
  assign is_and   = (op_sel == OP_AND);

  assign imm_ext  = is_and ? {{XW{1'b0}}, imm} : {{XW{imm[IW-1]}}, imm};
  assign rhs      = use_imm ? imm_ext : opnd_b;
  assign sum      = opnd_a + rhs;
  assign word_res = {{HW{sum[WW-1]}}, sum[WW-1:0]};

  assign ovf_w = (opnd_a[WW-1] == rhs[WW-1]) && (sum[WW-1] != opnd_a[WW-1]);
  assign ovf_d = (opnd_a[DW-1] == rhs[DW-1]) && (sum[DW-1] != opnd_a[DW-1]);

  always_comb begin
    if (is_word)       result = word_res;
    else if (is_dword) result = sum;
    else if (is_and)   result = opnd_a & rhs;
    else               result = '0;
  end

  assign ovf_trap = ((op_sel == OP_ADDW_T) && ovf_w) ||
                    ((op_sel == OP_ADDD_T) && ovf_d);
  assign wr_en    = (is_word || is_dword || is_and) && !ovf_trap;

  always_comb begin
    AST_TRAP_BLOCKS_WRITE: assert (!(ovf_trap && wr_en)); // R8
    if (op_sel == OP_ADDW_U)
      AST_WORD_WRAP_NO_TRAP: assert (!ovf_trap); // R2
    if (op_sel == OP_ADDD_U)
      AST_DWORD_WRAP_NO_TRAP: assert (!ovf_trap); // R4
    if (is_word)
      AST_WORD_SEXT: assert (result[DW-1:WW] == {HW{result[WW-1]}}); // R6
    if (is_and && use_imm)
      AST_ANDI_ZERO_TOP: assert (result[DW-1:IW] == '0); // R7
    if (!(is_word || is_dword || is_and))
      AST_RESERVED_IDLE: assert (!wr_en && !ovf_trap && result == '0); // R9
  end

endmodule

// File: tb/test_int_add_logic_unit.sv
module test_int_add_logic_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic [2:0]  op_sel = '0;
  logic        use_imm = 1'b0;
  logic [63:0] result;
  logic        ovf_trap, wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] res;
    logic        trap;
    logic        we;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5ns clk = ~clk;

  int_add_logic_unit i_int_add_logic_unit (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .op_sel(op_sel),
    .use_imm(use_imm), .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
  );

  task automatic drive(input logic [2:0] op, input logic ui, input logic [63:0] a,
                       input logic [63:0] b, input logic [15:0] im, input string tag);
    exp_t e;
    logic [63:0] r;
    logic signed [32:0] s32;
    logic signed [64:0] s64;
    @(negedge clk);
    r = ui ? ((op == 3'd4) ? {48'd0, im} : {{48{im[15]}}, im}) : b;
    e.tag = tag;
    e.trap = 1'b0;
    e.we = 1'b1;
    case (op)
      3'd0, 3'd1: begin
        s32 = $signed({a[31], a[31:0]}) + $signed({r[31], r[31:0]});
        e.res = {{32{s32[31]}}, s32[31:0]};
        e.trap = (op == 3'd0) && (s32[32] != s32[31]);
      end
      3'd2, 3'd3: begin
        s64 = $signed({a[63], a}) + $signed({r[63], r});
        e.res = s64[63:0];
        e.trap = (op == 3'd2) && (s64[64] != s64[63]);
      end
      3'd4: e.res = a & r;
      default: begin e.res = '0; e.we = 1'b0; end
    endcase
    if (e.trap) e.we = 1'b0;
    op_sel = op; use_imm = ui; opnd_a = a; opnd_b = b; imm = im;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res || ovf_trap !== e.trap || wr_en !== e.we) begin
        errors++;
        $display("FAIL %s: got res=%h trap=%b we=%b, expected res=%h trap=%b we=%b",
                 e.tag, result, ovf_trap, wr_en, e.res, e.trap, e.we);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(3'd0, 0, 64'd0, 64'd0, 16'd0, "R1 zero operands");
    drive(3'd0, 0, 64'h0000_0000_7fff_ffff, 64'd1, 16'd0, "R1 R8 word overflow");
    drive(3'd0, 1, 64'h0000_0000_7fff_fff0, 64'd0, 16'h0010, "R1 R5 imm word overflow");
    drive(3'd0, 0, 64'h0000_0000_ffff_ffff, 64'd1, 16'd0, "R1 -1+1 no trap");
    drive(3'd0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 16'd0, "R1 negative overflow");
    drive(3'd1, 0, 64'h0000_0000_7fff_ffff, 64'd1, 16'd0, "R2 wrap no trap");
    drive(3'd1, 1, 64'd0, 64'd0, 16'hffff, "R2 R5 imm -1");
    drive(3'd1, 0, 64'hdead_beef_ffff_ffff, 64'h1234_0000_ffff_ffff, 16'd0, "R6 upper ignored");
    drive(3'd2, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 16'd0, "R3 dword overflow");
    drive(3'd2, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'd0, "R3 negative overflow");
    drive(3'd2, 0, 64'h0000_0000_7fff_ffff, 64'd1, 16'd0, "R3 no trap at bit31");
    drive(3'd2, 1, 64'd5, 64'd0, 16'hffff, "R5 dword imm -1");
    drive(3'd3, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 16'd0, "R4 wrap no trap");
    drive(3'd3, 1, 64'd0, 64'd0, 16'h8000, "R5 imm sign bit");
    drive(3'd4, 0, 64'hf0f0_1234_ffff_0000, 64'h0ff0_ff00_00ff_ffff, 16'd0, "R7 and register");
    drive(3'd4, 1, 64'hffff_ffff_ffff_ffff, 64'd0, 16'hffff, "R7 and imm zero-ext");
    drive(3'd5, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 16'd0, "R9 reserved 5");
    drive(3'd7, 1, 64'hffff_ffff_ffff_ffff, 64'd0, 16'hffff, "R9 reserved 7");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule